// File: doc/BRIEF.md
# Flash Bulk Erase Sequencer

This block runs the whole bulk-erase procedure on a byte-wide flash array from the host side. The array is a bus slave reached through a single-cycle write strobe, a single-cycle read strobe, an address bus and a write-data bus. One pulse on `start_i` starts a run. The block first writes 00h to every byte in ascending address order. It then sends the two-cycle erase command (20h written twice in a row) and holds off for a programmable erase-pulse time. After that it walks the array with verify pairs: a write of A0h that carries the byte's address, a mandatory quiet gap, and then a one-cycle read of the same address.

A byte that reads back FFh counts as erased, and the walk moves on to the next address. If a byte reads back any other value, the block issues another erase command and pulse. It then resumes the verify walk at the failing address, so addresses that already passed are not read again. The block counts erase pulses. If a byte still fails after the last permitted pulse, the block stops with `fail_o` set. After the highest address passes, `done_o` is set. Both flags hold until the next start.

The address counter wraps past the last byte, so `addr_o` reads 0 at the end of the precondition pass and again at completion. The quiet gap between the end of the verify write and the read is a parameter. Set it to cover the array's minimum write-high to read-low time (6 µs), counted in clock cycles.

Top module: `erase_seq`

## Requirements
- R1: Out of reset, and while idle, busy_o, done_o, fail_o, wr_o and rd_o are all low, wr_data_o is 00h and addr_o is 0.
- R2: After start, the block writes 00h to every address from 0 up to 2**ADDR_W-1, one write per cycle, before any other bus cycle.
- R3: Every erase command is two consecutive write cycles carrying 20h at the current address, and the pulse counter advances once per command.
- R4: After the second 20h write, exactly PULSE_CYC idle cycles (no write, no read) pass before the first verify write.
- R5: A verify is a write of A0h at address A, followed by exactly GAP_CYC idle cycles, followed by one read cycle at address A; wr_o and rd_o are never high together.
- R6: A verify read of FFh sampled at the end of the read cycle passes the byte, and the next verify starts at A+1 on the following cycle.
- R7: A verify read other than FFh, with fewer than MAX_PULSES erase commands issued in this run, starts a new erase command on the next cycle and resumes verifying at the same address A.
- R8: A failing verify read after MAX_PULSES erase commands enters a stop state: fail_o high, busy_o low, addr_o held at the failing address, no bus cycles; this holds until the next start.
- R9: When address 2**ADDR_W-1 passes, the block enters a completion state: done_o high, busy_o low, addr_o 0, no bus cycles; this holds until the next start.
- R10: start_i is ignored while busy_o is high, and a start from the completion or stop state begins a fresh run with the pulse count cleared.
- R11: wr_data_o is 00h in every cycle in which wr_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when not busy |
| rd_data_i | input | 8 | Read data from the array, sampled at the end of a read cycle |
| addr_o | output | ADDR_W | Byte address |
| wr_data_o | output | 8 | Write data / command byte |
| wr_o | output | 1 | Single-cycle write strobe |
| rd_o | output | 1 | Single-cycle read strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed, all bytes verified |
| fail_o | output | 1 | Run stopped, erase pulses exhausted |

## Verification
The bench drives a flash model in which each byte needs its own number of erase pulses before it reads FFh. It runs four patterns. In the first, every byte erases on the first pulse, which exercises the straight walk. In the second, scattered bytes need extra pulses, which shows whether verification resumes at the failing address or restarts from zero. In the third, one byte needs exactly the maximum pulse count, which separates an off-by-one in the retry limit from a correct limit. In the fourth, one byte never erases in time, which must end in the stop state at that address. A start pulse injected mid-run shows that busy runs cannot be restarted, and every cycle's bus outputs are compared against an independently built expected trace.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ERS1, S_ERS2, S_PULSE, S_VSET, S_VGAP, S_VRD, S_DONE, S_FAIL
  } state_e;

  localparam logic [7:0] PRE_DATA   = 8'h00;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] ERASED     = 8'hFF;
endpackage

// File: rtl/erase_addr_ctr.sv
module erase_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + 1'b1;  // wraps past the top byte
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/erase_pulse_ctr.sv
module erase_pulse_ctr #(
  parameter int MAX_PULSES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic spent_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PULSES);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = (cnt_q == LIMIT);
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PULSE_CYC  = 500000,
  parameter int GAP_CYC    = 300,
  parameter int MAX_PULSES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  localparam int TMR_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD   = TMR_W'(GAP_CYC - 1);

  state_e state_q, state_d;
  logic   addr_clr, addr_inc, addr_last;
  logic   tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic   pls_clr, pls_inc, pls_spent;

  erase_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .clr_i(addr_clr), .inc_i(addr_inc),
    .addr_o(addr_o), .last_o(addr_last)
  );

  erase_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  erase_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pls (
    .clk_i, .rst_ni, .clr_i(pls_clr), .inc_i(pls_inc), .spent_o(pls_spent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d  = state_q;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = PULSE_LD;
    pls_clr  = 1'b0;
    pls_inc  = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start_i) begin
          state_d  = S_PRE;
          addr_clr = 1'b1;
          pls_clr  = 1'b1;
        end
      end
      S_PRE: begin
        addr_inc = 1'b1;
        if (addr_last) state_d = S_ERS1;
      end
      S_ERS1: state_d = S_ERS2;
      S_ERS2: begin
        pls_inc  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = PULSE_LD;
        state_d  = S_PULSE;
      end
      S_PULSE: if (tmr_zero) state_d = S_VSET;
      S_VSET: begin
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
        state_d  = S_VGAP;
      end
      S_VGAP: if (tmr_zero) state_d = S_VRD;
      S_VRD: begin
        if (rd_data_i == ERASED) begin
          addr_inc = 1'b1;
          state_d  = addr_last ? S_DONE : S_VSET;
        end else begin
          state_d  = pls_spent ? S_FAIL : S_ERS1;  // resume at same address
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    wr_o      = 1'b0;
    wr_data_o = PRE_DATA;
    unique case (state_q)
      S_PRE:          wr_o = 1'b1;
      S_ERS1, S_ERS2: begin wr_o = 1'b1; wr_data_o = CMD_ERASE;  end
      S_VSET:         begin wr_o = 1'b1; wr_data_o = CMD_VERIFY; end
      default: ;
    endcase
  end

  assign rd_o   = (state_q == S_VRD);
  assign done_o = (state_q == S_DONE);
  assign fail_o = (state_q == S_FAIL);
  assign busy_o = !(state_q inside {S_IDLE, S_DONE, S_FAIL});
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int ADDR_W  = 4,
  parameter int GAP_CYC = 300
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [7:0]        wr_data_o,
  input logic              wr_o,
  input logic              rd_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);
  int                gap_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              ers_wr;

  assign ers_wr = wr_o && (wr_data_o == 8'h20);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= 0;
      vaddr_q <= '0;
    end else begin
      if (wr_o)                gap_q <= 0;
      else if (gap_q < GAP_CYC) gap_q <= gap_q + 1;
      if (wr_o && wr_data_o == 8'hA0) vaddr_q <= addr_o;
    end
  end

  p_no_wr_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && rd_o));

  p_read_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> gap_q >= GAP_CYC);

  p_read_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> addr_o == vaddr_q);

  p_erase_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ers_wr && !$past(ers_wr)) |=> ers_wr);

  p_data_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_o |-> wr_data_o == 8'h00);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_o && !rd_o);

  p_flags_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, fail_o}));

  p_fail_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o && $stable(addr_o));

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && addr_o == '0);
endmodule

bind erase_seq erase_seq_chk #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_o(addr_o),
  .wr_data_o(wr_data_o), .wr_o(wr_o), .rd_o(rd_o), .busy_o(busy_o),
  .done_o(done_o), .fail_o(fail_o)
);

// File: tb/tb_erase_seq.sv
module tb_erase_seq;
  localparam int AW    = 4;
  localparam int N     = 1 << AW;
  localparam int PULSE = 12;
  localparam int GAP   = 5;
  localparam int MAXP  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    rd_data;
  logic [AW-1:0] addr;
  logic [7:0]    wr_data;
  logic          wr, rd, busy, done, fail;

  erase_seq #(.ADDR_W(AW), .PULSE_CYC(PULSE), .GAP_CYC(GAP), .MAX_PULSES(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_data_i(rd_data),
    .addr_o(addr), .wr_data_o(wr_data), .wr_o(wr), .rd_o(rd),
    .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_tests = 0, n_fail = 0, cycles = 0;
  int need [N];
  int ers_writes = 0;

  // flash model: byte reads FFh once enough erase commands have been seen
  assign rd_data = !rd ? 8'h55 : ((ers_writes / 2 >= need[addr]) ? 8'hFF : 8'h3C);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (wr && wr_data == 8'h20) ers_writes <= ers_writes + 1;
  end

  logic [16:0] q_vec[$];
  string       q_tag[$];

  task automatic push(bit b, bit d, bit f, bit w, bit r, int a, int dat, string tag);
    q_vec.push_back({b, d, f, w, r, 4'(a), 8'(dat)});
    q_tag.push_back(tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles > 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    summary();
  end

  task automatic check(logic [16:0] exp, string tag);
    logic [16:0] act;
    act = {busy, done, fail, wr, rd, addr, wr_data};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (busy,done,fail,wr,rd,addr,data)", tag, act, exp);
    end
  endtask

  // expected trace built from the requirements
  task automatic build(output bit ok);
    int cur, pulses;
    bit passed;
    for (int a = 0; a < N; a++) push(1, 0, 0, 1, 0, a, 8'h00, "R2");
    cur = 0; pulses = 0;
    forever begin
      push(1, 0, 0, 1, 0, cur, 8'h20, "R3");
      push(1, 0, 0, 1, 0, cur, 8'h20, "R3");
      pulses++;
      for (int i = 0; i < PULSE; i++) push(1, 0, 0, 0, 0, cur, 0, "R4");
      forever begin
        push(1, 0, 0, 1, 0, cur, 8'hA0, "R5");
        for (int i = 0; i < GAP; i++) push(1, 0, 0, 0, 0, cur, 0, "R5");
        push(1, 0, 0, 0, 1, cur, 0, "R5");
        passed = (pulses >= need[cur]);
        if (!passed) break;
        cur++;
        if (cur == N) begin
          for (int i = 0; i < 3; i++) push(0, 1, 0, 0, 0, 0, 0, "R9");
          ok = 1; return;
        end
      end
      if (pulses == MAXP) begin
        for (int i = 0; i < 3; i++) push(0, 0, 1, 0, 0, cur, 0, "R8");
        ok = 0; return;
      end
      // R7: next erase command stays at failing address
    end
  endtask

  task automatic run(string name, int inject_at);
    bit ok;
    int idx;
    q_vec.delete(); q_tag.delete();
    build(ok);
    @(negedge clk);
    ers_writes = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    while (q_vec.size() > 0) begin
      check(q_vec.pop_front(), q_tag.pop_front());
      start = (idx == inject_at);  // R10: start while busy must be ignored
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
    n_tests++;
    if (done !== ok || fail !== !ok) begin
      n_fail++;
      $display("FAIL %s R8/R9 end flags: actual done=%b fail=%b expected done=%b",
               name, done, fail, ok);
    end
  endtask

  initial begin
    for (int a = 0; a < N; a++) need[a] = 1;
    repeat (3) @(negedge clk);
    check(17'h0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) begin @(negedge clk); check(17'h0, "R1 idle"); end

    run("all-first-pulse R6", -1);

    need[5] = 2; need[9] = 3;       // R7 resume at failing address
    run("scattered retries R7 R10", 30);

    for (int a = 0; a < N; a++) need[a] = 1;
    need[N-1] = MAXP;               // exactly the limit still completes
    run("limit boundary R9", -1);

    for (int a = 0; a < N; a++) need[a] = 1;
    need[3] = MAXP + 1;             // exhausted
    run("exhausted R8", -1);

    // R10: restart from stop state clears the pulse count and passes
    for (int a = 0; a < N; a++) need[a] = 1;
    run("restart after stop R10", -1);

    summary();
  end
endmodule